// File: doc/BRIEF.md
# Low-Power Seconds Counter with Alarm

This peripheral keeps time in a slow, always-on clock domain while software reaches it through a 32-bit register port clocked by a fast bus clock. A free-running count advances by one on every slow-clock edge while counting is switched on. The bottom `SUB_W` bits of the count are sub-second ticks, and the 32 bits above them are whole seconds. A programmable alarm is compared against the seconds field. A match raises a sticky flag, and that flag drives an interrupt output and a wakeup output in the bus domain.

The two clock domains are linked by synchronisers and two small state machines. The bus-side command machine has the states XF_IDLE and XF_WAIT. In XF_IDLE it picks one pending command, choosing a status clear first, then an alarm update, then a counter load. It latches that command, toggles a request and moves to XF_WAIT. It returns to XF_IDLE once the slow domain's acknowledge toggle, synchronised back, matches the request. The slow-side snapshot machine has the states SN_CAPT and SN_WAIT. In SN_CAPT it copies the whole count into a hold register, toggles a request and moves to SN_WAIT. It goes back to SN_CAPT once the bus side has taken the copy and returned the toggle.

The enable bits for counting, alarm and wakeup cross as plain levels through two-flop synchronisers. Software learns that counting has really started or stopped by polling the enable bit it reads back. The count is read as two separate words, so a read of both words while counting is not atomic.

Top module: `lp_rtc_alarm`

## Requirements
- R1: After reset, every register reads zero except status, which reads 0x2 because the glitch bit is set. `irq_o` and `wake_o` are 0.
- R2: While counting is applied in the slow domain, the count grows by exactly one per slow-clock edge and wraps at its full width. While counting is off, the count holds its value.
- R3: The control register at 0x04 holds counting enable in bit 0, alarm enable in bit 1 and wakeup enable in bit 3. Bits 1 and 3 read back as written. Bit 0 reads back the enable actually applied in the slow domain, so after a write it changes only after a delay of a few slow-clock cycles.
- R4: The count reads as a low word at 0x20, holding count bits 31:0, and a high word at 0x1C, holding the remaining bits in its lowest bits with the upper bits zero. Writes to these words take effect only while both the written and the read-back counting enable are 0. Other writes are ignored, as are high-word data bits above the count width.
- R5: The alarm register at 0x24 holds a 32-bit seconds value and reads back as written.
- R6: Status bit 0 (alarm flag) sets on a slow edge where alarm enable is applied and the seconds field equals the alarm value. It then stays set until it is cleared, even if alarm enable is later dropped.
- R7: Writing 1 to status bit 0 clears the alarm flag. Writing 0 there leaves the flag unchanged. Writing to status bit 1 has no effect. When a match and a clear occur on the same edge, the match wins.
- R8: `irq_o` equals the alarm flag AND alarm enable, and `wake_o` equals the alarm flag AND wakeup enable. Both are brought into the bus domain through two flip-flops.
- R9: The glitch register at 0x30 reads back as written. Status bit 1 reads 1 unless that register holds 0x41736166.
- R10: A read of the count returns a whole value captured on a single slow edge. Once counting is off and pending transfers have settled, both words return exactly the held count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Fast register-port clock |
| bus_rst_n | input | 1 | Active-low asynchronous reset, bus domain |
| slow_clk | input | 1 | Slow always-on counting clock |
| slow_rst_n | input | 1 | Active-low asynchronous reset, slow domain |
| bus_wr | input | 1 | Write strobe, one bus cycle per write |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Alarm interrupt, bus domain |
| wake_o | output | 1 | Wakeup request, bus domain |

## Verification
On every cycle, assertions check the following:
- the single-step and hold behaviour of the count;
- that the alarm flag rises only after a match and then stays set;
- that the command payload does not change while a transfer is in flight;
- that blocked counter writes leave the load register untouched;
- that the bus snapshot changes only when a new capture is handed over.

Other behaviours can only be shown by the bench scenarios:
- the lag of the enable read-back;
- exact register values after loads;
- how many counts elapse over a timed run;
- the alarm firing at a seconds boundary;
- the effect of different enable combinations on `irq_o` and `wake_o`;
- the write-one-to-clear rules.

// File: rtl/lprtc_pkg.sv
package lprtc_pkg;
    localparam int SEC_W = 32;
    localparam logic [7:0] A_CTRL   = 8'h04;
    localparam logic [7:0] A_STAT   = 8'h18;
    localparam logic [7:0] A_CNT_HI = 8'h1C;
    localparam logic [7:0] A_CNT_LO = 8'h20;
    localparam logic [7:0] A_ALARM  = 8'h24;
    localparam logic [7:0] A_GLITCH = 8'h30;
    localparam logic [31:0] GLITCH_KEY = 32'h4173_6166;

    typedef enum logic [1:0] {
        CMD_NONE  = 2'd0,
        CMD_CLEAR = 2'd1,
        CMD_ALARM = 2'd2,
        CMD_LOAD  = 2'd3
    } cmd_e;

    typedef enum logic {XF_IDLE, XF_WAIT} xfer_state_e;
    typedef enum logic {SN_CAPT, SN_WAIT} snap_state_e;
endpackage

// File: rtl/lprtc_sync2.sv
module lprtc_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d;
            stage2_q <= stage1_q;
        end
    end

    assign q = stage2_q;
endmodule

// File: rtl/lprtc_bus_if.sv
module lprtc_bus_if
    import lprtc_pkg::*;
#(
    parameter int SUB_W = 15,
    localparam int CNT_W = SEC_W + SUB_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [7:0]       bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    output logic             run_lvl,
    output logic             alm_lvl,
    output logic             wake_lvl,
    output logic             cmd_req_t,
    output cmd_e             cmd_kind,
    output logic [CNT_W-1:0] cmd_data,
    input  logic             cmd_ack_t,
    input  logic             snap_req_t,
    input  logic [CNT_W-1:0] snap_data,
    output logic             snap_ack_t,
    input  logic             run_s,
    input  logic             flag_s,
    input  logic             irq_s,
    input  logic             wake_s,
    output logic             irq_o,
    output logic             wake_o
);
    logic             run_q, alm_q, wake_q;
    logic [SEC_W-1:0] alarm_q;
    logic [31:0]      glitch_q;
    logic [CNT_W-1:0] load_q;
    logic             pend_clr_q, pend_alarm_q, pend_load_q;
    logic             ack_sync, snap_req_sync;
    logic             run_rb, flag_rb;
    logic [3:0]       stat_sync;
    logic [CNT_W-1:0] snap_q;
    logic             snap_ack_q;
    logic             req_q;
    cmd_e             kind_q;
    logic [CNT_W-1:0] data_q;
    xfer_state_e      xf_q, xf_d;
    cmd_e             take;
    logic [CNT_W-1:0] payload;

    wire wr_ctrl   = bus_wr && (bus_addr == A_CTRL);
    wire wr_stat   = bus_wr && (bus_addr == A_STAT);
    wire wr_hi     = bus_wr && (bus_addr == A_CNT_HI);
    wire wr_lo     = bus_wr && (bus_addr == A_CNT_LO);
    wire wr_alarm  = bus_wr && (bus_addr == A_ALARM);
    wire wr_glitch = bus_wr && (bus_addr == A_GLITCH);
    wire cnt_open  = !run_q && !run_rb;

    lprtc_sync2 #(.W(1)) u_ack_sync (.clk(clk), .rst_n(rst_n), .d(cmd_ack_t), .q(ack_sync));
    lprtc_sync2 #(.W(1)) u_snap_sync (.clk(clk), .rst_n(rst_n), .d(snap_req_t), .q(snap_req_sync));
    lprtc_sync2 #(.W(4)) u_stat_sync (.clk(clk), .rst_n(rst_n),
                                      .d({wake_s, irq_s, flag_s, run_s}), .q(stat_sync));

    assign run_rb  = stat_sync[0];
    assign flag_rb = stat_sync[1];
    assign irq_o   = stat_sync[2];
    assign wake_o  = stat_sync[3];

    // Register file on the bus side
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q    <= 1'b0;
            alm_q    <= 1'b0;
            wake_q   <= 1'b0;
            alarm_q  <= '0;
            glitch_q <= '0;
            load_q   <= '0;
        end else begin
            if (wr_ctrl) begin
                run_q  <= bus_wdata[0];
                alm_q  <= bus_wdata[1];
                wake_q <= bus_wdata[3];
            end
            if (wr_alarm)  alarm_q  <= bus_wdata;
            if (wr_glitch) glitch_q <= bus_wdata;
            if (wr_lo && cnt_open) load_q[31:0] <= bus_wdata;
            if (wr_hi && cnt_open) load_q[CNT_W-1:32] <= bus_wdata[SUB_W-1:0];
        end
    end

    // Pending commands: a new write wins over a take in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_clr_q   <= 1'b0;
            pend_alarm_q <= 1'b0;
            pend_load_q  <= 1'b0;
        end else begin
            pend_clr_q   <= (wr_stat && bus_wdata[0]) || (pend_clr_q && take != CMD_CLEAR);
            pend_alarm_q <= wr_alarm || (pend_alarm_q && take != CMD_ALARM);
            pend_load_q  <= ((wr_lo || wr_hi) && cnt_open) || (pend_load_q && take != CMD_LOAD);
        end
    end

    // Command transfer machine: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) xf_q <= XF_IDLE;
        else        xf_q <= xf_d;
    end

    // Command transfer machine: next state and selection
    always_comb begin
        xf_d = xf_q;
        take = CMD_NONE;
        unique case (xf_q)
            XF_IDLE: begin
                if (pend_clr_q)        take = CMD_CLEAR;
                else if (pend_alarm_q) take = CMD_ALARM;
                else if (pend_load_q)  take = CMD_LOAD;
                if (take != CMD_NONE) xf_d = XF_WAIT;
            end
            XF_WAIT: begin
                if (ack_sync == req_q) xf_d = XF_IDLE;
            end
        endcase
    end

    always_comb begin
        case (take)
            CMD_CLEAR: payload = {{(CNT_W-1){1'b0}}, 1'b1};
            CMD_ALARM: payload = {{SUB_W{1'b0}}, alarm_q};
            CMD_LOAD:  payload = load_q;
            default:   payload = '0;
        endcase
    end

    // Command transfer machine: outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q  <= 1'b0;
            kind_q <= CMD_NONE;
            data_q <= '0;
        end else if (take != CMD_NONE) begin
            req_q  <= ~req_q;
            kind_q <= take;
            data_q <= payload;
        end
    end

    // Snapshot receiver
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_q     <= '0;
            snap_ack_q <= 1'b0;
        end else if (snap_req_sync != snap_ack_q) begin
            snap_q     <= snap_data;
            snap_ack_q <= snap_req_sync;
        end
    end

    assign run_lvl    = run_q;
    assign alm_lvl    = alm_q;
    assign wake_lvl   = wake_q;
    assign cmd_req_t  = req_q;
    assign cmd_kind   = kind_q;
    assign cmd_data   = data_q;
    assign snap_ack_t = snap_ack_q;

    always_comb begin
        case (bus_addr)
            A_CTRL:   bus_rdata = {28'b0, wake_q, 1'b0, alm_q, run_rb};
            A_STAT:   bus_rdata = {30'b0, glitch_q != GLITCH_KEY, flag_rb};
            A_CNT_HI: bus_rdata = {{(32-SUB_W){1'b0}}, snap_q[CNT_W-1:32]};
            A_CNT_LO: bus_rdata = snap_q[31:0];
            A_ALARM:  bus_rdata = alarm_q;
            A_GLITCH: bus_rdata = glitch_q;
            default:  bus_rdata = '0;
        endcase
    end

    p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (xf_q == XF_WAIT) |=> ($stable(data_q) && $stable(kind_q)));

    p_cnt_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_lo || wr_hi) && run_q) |=> $stable(load_q));

    p_snap_update_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(snap_q) |-> $past(snap_req_sync != snap_ack_q));
endmodule

// File: rtl/lprtc_core.sv
module lprtc_core
    import lprtc_pkg::*;
#(
    parameter int SUB_W = 15,
    localparam int CNT_W = SEC_W + SUB_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_lvl,
    input  logic             alm_lvl,
    input  logic             wake_lvl,
    input  logic             cmd_req_t,
    input  cmd_e             cmd_kind,
    input  logic [CNT_W-1:0] cmd_data,
    output logic             cmd_ack_t,
    input  logic             snap_ack_t,
    output logic             snap_req_t,
    output logic [CNT_W-1:0] snap_data,
    output logic             run_s,
    output logic             flag_s,
    output logic             irq_s,
    output logic             wake_s
);
    logic [2:0]       ctrl_sync;
    logic             alm_en_s, wake_en_s;
    logic             req_sync, snap_ack_sync;
    logic             ack_q;
    logic [CNT_W-1:0] count_q;
    logic [SEC_W-1:0] alarm_q;
    logic             flag_q, irq_q, wake_q;
    logic [CNT_W-1:0] hold_q;
    logic             snap_req_q;
    snap_state_e      sn_q, sn_d;
    logic             do_capture;

    lprtc_sync2 #(.W(3)) u_ctrl_sync (.clk(clk), .rst_n(rst_n),
                                      .d({wake_lvl, alm_lvl, run_lvl}), .q(ctrl_sync));
    lprtc_sync2 #(.W(1)) u_req_sync (.clk(clk), .rst_n(rst_n), .d(cmd_req_t), .q(req_sync));
    lprtc_sync2 #(.W(1)) u_sack_sync (.clk(clk), .rst_n(rst_n), .d(snap_ack_t), .q(snap_ack_sync));

    assign run_s     = ctrl_sync[0];
    assign alm_en_s  = ctrl_sync[1];
    assign wake_en_s = ctrl_sync[2];

    wire new_cmd     = (req_sync != ack_q);
    wire apply_load  = new_cmd && (cmd_kind == CMD_LOAD) && !run_s;
    wire apply_alarm = new_cmd && (cmd_kind == CMD_ALARM);
    wire apply_clear = new_cmd && (cmd_kind == CMD_CLEAR) && cmd_data[0];
    wire match       = alm_en_s && (count_q[CNT_W-1:SUB_W] == alarm_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_q   <= 1'b0;
            count_q <= '0;
            alarm_q <= '0;
            flag_q  <= 1'b0;
            irq_q   <= 1'b0;
            wake_q  <= 1'b0;
        end else begin
            if (new_cmd) ack_q <= req_sync;
            if (apply_load)  count_q <= cmd_data;
            else if (run_s)  count_q <= count_q + 1'b1;
            if (apply_alarm) alarm_q <= cmd_data[SEC_W-1:0];
            if (match)            flag_q <= 1'b1;
            else if (apply_clear) flag_q <= 1'b0;
            irq_q  <= flag_q && alm_en_s;
            wake_q <= flag_q && wake_en_s;
        end
    end

    // Snapshot machine: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sn_q <= SN_CAPT;
        else        sn_q <= sn_d;
    end

    // Snapshot machine: next state
    always_comb begin
        sn_d       = sn_q;
        do_capture = 1'b0;
        unique case (sn_q)
            SN_CAPT: begin
                do_capture = 1'b1;
                sn_d       = SN_WAIT;
            end
            SN_WAIT: begin
                if (snap_ack_sync == snap_req_q) sn_d = SN_CAPT;
            end
        endcase
    end

    // Snapshot machine: outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q     <= '0;
            snap_req_q <= 1'b0;
        end else if (do_capture) begin
            hold_q     <= count_q;
            snap_req_q <= ~snap_req_q;
        end
    end

    assign cmd_ack_t  = ack_q;
    assign snap_req_t = snap_req_q;
    assign snap_data  = hold_q;
    assign flag_s     = flag_q;
    assign irq_s      = irq_q;
    assign wake_s     = wake_q;

    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_s && !apply_load) |=> (count_q == $past(count_q) + 1'b1));

    p_count_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_s && !apply_load) |=> $stable(count_q));

    p_flag_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(match));

    p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !apply_clear) |=> flag_q);

    p_hold_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sn_q == SN_WAIT) |=> $stable(hold_q));
endmodule

// File: rtl/lp_rtc_alarm.sv
module lp_rtc_alarm
    import lprtc_pkg::*;
#(
    parameter int SUB_W = 15
) (
    input  logic        bus_clk,
    input  logic        bus_rst_n,
    input  logic        slow_clk,
    input  logic        slow_rst_n,
    input  logic        bus_wr,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq_o,
    output logic        wake_o
);
    localparam int CNT_W = SEC_W + SUB_W;

    logic             run_lvl, alm_lvl, wake_lvl;
    logic             cmd_req_t, cmd_ack_t;
    cmd_e             cmd_kind;
    logic [CNT_W-1:0] cmd_data;
    logic             snap_req_t, snap_ack_t;
    logic [CNT_W-1:0] snap_data;
    logic             run_s, flag_s, irq_s, wake_s;

    lprtc_bus_if #(.SUB_W(SUB_W)) u_bus (
        .clk(bus_clk), .rst_n(bus_rst_n),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .run_lvl(run_lvl), .alm_lvl(alm_lvl), .wake_lvl(wake_lvl),
        .cmd_req_t(cmd_req_t), .cmd_kind(cmd_kind), .cmd_data(cmd_data), .cmd_ack_t(cmd_ack_t),
        .snap_req_t(snap_req_t), .snap_data(snap_data), .snap_ack_t(snap_ack_t),
        .run_s(run_s), .flag_s(flag_s), .irq_s(irq_s), .wake_s(wake_s),
        .irq_o(irq_o), .wake_o(wake_o)
    );

    lprtc_core #(.SUB_W(SUB_W)) u_core (
        .clk(slow_clk), .rst_n(slow_rst_n),
        .run_lvl(run_lvl), .alm_lvl(alm_lvl), .wake_lvl(wake_lvl),
        .cmd_req_t(cmd_req_t), .cmd_kind(cmd_kind), .cmd_data(cmd_data), .cmd_ack_t(cmd_ack_t),
        .snap_ack_t(snap_ack_t), .snap_req_t(snap_req_t), .snap_data(snap_data),
        .run_s(run_s), .flag_s(flag_s), .irq_s(irq_s), .wake_s(wake_s)
    );
endmodule

// File: tb/test_lp_rtc_alarm.sv
module test_lp_rtc_alarm;
    logic        bus_clk = 1'b0;
    logic        slow_clk = 1'b0;
    logic        bus_rst_n = 1'b0;
    logic        slow_rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        irq_o, wake_o;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 bus_clk = ~bus_clk;
    always #85 slow_clk = ~slow_clk;

    lp_rtc_alarm i_lp_rtc_alarm (
        .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .slow_clk(slow_clk), .slow_rst_n(slow_rst_n),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .wake_o(wake_o)
    );

    function automatic logic [31:0] exp_hi(input logic [46:0] v);
        return {17'b0, v[46:32]};
    endfunction

    function automatic logic [31:0] exp_lo(input logic [46:0] v);
        return v[31:0];
    endfunction

    function automatic logic [46:0] sec_count(input logic [31:0] sec, input logic [14:0] sub);
        return {sec, sub};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic chk_range(input string req, input logic [63:0] act,
                             input logic [63:0] lo, input logic [63:0] hi);
        n_checks++;
        if (act < lo || act > hi) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge bus_clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge bus_clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge bus_clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_slow(input int n);
        repeat (n) @(posedge slow_clk);
        @(negedge bus_clk);
    endtask

    task automatic rd_count(output logic [46:0] v);
        logic [31:0] lo, hi;
        rd(8'h20, lo);
        rd(8'h1C, hi);
        v = {hi[14:0], lo};
    endtask

    // Stop, clear, preload one second below the alarm, then start with ctrl bits
    task automatic run_alarm(input logic [31:0] sec, input logic [31:0] ctl);
        logic [46:0] c;
        logic [31:0] st;
        c = sec_count(sec - 1, 15'h7FE8);
        wr(8'h04, 32'h0);
        wait_slow(10);
        wr(8'h18, 32'h1);
        wr(8'h20, exp_lo(c));
        wr(8'h1C, exp_hi(c));
        wr(8'h24, sec);
        wait_slow(30);
        wr(8'h04, ctl | 32'h1);
        wait_slow(8);
        rd(8'h18, st);
        chk("R6 no flag before match", {31'b0, st[0]}, 32'h0);
        wait_slow(70);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge bus_clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] d;
        logic [46:0] v, v2, c0;
        void'($urandom(32'd4242));
        repeat (4) @(posedge slow_clk);
        bus_rst_n = 1'b1;
        slow_rst_n = 1'b1;
        wait_slow(4);

        // R1 reset state
        rd(8'h04, d); chk("R1 ctrl", d, 32'h0);
        rd(8'h18, d); chk("R1 status", d, 32'h2);
        rd(8'h20, d); chk("R1 count lo", d, 32'h0);
        rd(8'h1C, d); chk("R1 count hi", d, 32'h0);
        rd(8'h24, d); chk("R1 alarm", d, 32'h0);
        chk("R1 irq/wake", {30'b0, wake_o, irq_o}, 32'h0);

        // R9 glitch register
        wr(8'h30, 32'h1234_5678);
        rd(8'h30, d); chk("R9 glitch readback", d, 32'h1234_5678);
        rd(8'h18, d); chk("R9 wrong key keeps bit1", d & 32'h2, 32'h2);
        wr(8'h30, 32'h4173_6166);
        rd(8'h18, d); chk("R9 key clears bit1", d & 32'h2, 32'h0);
        wr(8'h18, 32'h2);
        rd(8'h18, d); chk("R7 status bit1 write ignored", d & 32'h2, 32'h0);

        // R4 / R10 load while stopped
        c0 = 47'h1ABC_DEF0_1234;
        wr(8'h20, exp_lo(c0));
        wr(8'h1C, 32'hFFFF_0000 | exp_hi(c0));
        wait_slow(20);
        rd(8'h20, d); chk("R4 lo after load", d, exp_lo(c0));
        rd(8'h1C, d); chk("R4 hi after load, upper bits dropped", d, exp_hi(c0));

        // R3 enable readback lag
        wr(8'h04, 32'h1);
        rd(8'h04, d); chk("R3 enable not yet applied", d, 32'h0);
        wait_slow(6);
        rd(8'h04, d); chk("R3 enable applied", d, 32'h1);

        // R4 write while counting ignored
        wr(8'h20, 32'h0);
        wr(8'h1C, 32'h0);
        wait_slow(94);
        wr(8'h04, 32'h0);
        wait_slow(20);
        rd(8'h04, d); chk("R3 disable applied", d, 32'h0);
        rd_count(v);
        // R2 about 100 slow cycles elapsed between the two control writes
        chk_range("R2 counted cycles", v - c0, 64'd98, 64'd102);
        wait_slow(20);
        rd_count(v2);
        chk("R2 hold while stopped lo", v2[31:0], v[31:0]);
        chk("R4 counting write ignored hi", {17'b0, v2[46:32]}, exp_hi(c0));

        // R5 and R10 random loads and alarm values
        for (int i = 0; i < 10; i++) begin
            logic [46:0] rc;
            logic [31:0] ra;
            rc = {$urandom(), $urandom()};
            ra = $urandom();
            wr(8'h20, exp_lo(rc));
            wr(8'h1C, exp_hi(rc));
            wr(8'h24, ra);
            rd(8'h24, d); chk("R5 alarm readback", d, ra);
            wait_slow(20);
            rd(8'h20, d); chk("R10 random lo", d, exp_lo(rc));
            rd(8'h1C, d); chk("R10 random hi", d, exp_hi(rc));
        end

        // R6/R8 alarm with both outputs enabled
        run_alarm(32'h0000_1000, 32'hA);
        rd(8'h18, d); chk("R6 flag set at match", d & 32'h1, 32'h1);
        chk("R8 irq and wake", {30'b0, wake_o, irq_o}, 32'h3);
        rd(8'h04, d); chk("R3 ctrl bits", d, 32'hB);

        // R6 sticky after alarm enable drops, R8 gating
        wr(8'h04, 32'h9);
        wait_slow(8);
        rd(8'h18, d); chk("R6 flag sticky", d & 32'h1, 32'h1);
        chk("R8 irq gated, wake kept", {30'b0, wake_o, irq_o}, 32'h2);

        // R7 clear rules
        wr(8'h18, 32'h0);
        wait_slow(10);
        rd(8'h18, d); chk("R7 write zero keeps flag", d & 32'h1, 32'h1);
        wr(8'h18, 32'h1);
        wait_slow(10);
        rd(8'h18, d); chk("R7 write one clears flag", d & 32'h1, 32'h0);
        chk("R8 wake drops with flag", {30'b0, wake_o, irq_o}, 32'h0);

        // R6 no flag with alarm disabled
        run_alarm(32'h0000_2222, 32'h8);
        rd(8'h18, d); chk("R6 disabled alarm does not fire", d & 32'h1, 32'h0);
        chk("R8 no outputs", {30'b0, wake_o, irq_o}, 32'h0);

        // R8 interrupt only
        run_alarm(32'h7FFF_FFFF, 32'h2);
        rd(8'h18, d); chk("R6 flag at high seconds", d & 32'h1, 32'h1);
        chk("R8 irq only", {30'b0, wake_o, irq_o}, 32'h1);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule